// File: doc/BRIEF.md
# Flash Embedded-Operation Status Model

A synthesizable behavioural model of a small byte-wide flash array that is written through unlock command sequences and reports the progress of its internal operations on the read path. A host issues single-cycle write and read strobes. A write either advances the command decoder or, while an internal operation runs, is ignored. The only exceptions are a further sector-erase command inside the collection window and the reset command in the error state. A read returns one byte one cycle later, with `rd_valid` high. The returned byte is the stored data when the model is idle, and a status byte while an operation is running or an error is pending.

The array is split into equal sectors, and each sector can be locked by a control input. Stored bits can only move from 1 to 0 by programming. Only a sector erase or a whole-array erase brings a byte back to FFh. The program, erase, erase-window and locked-erase durations are parameters counted in clock cycles. The read interface has no back-pressure: every read strobe is answered exactly one cycle later. A read strobe in the same cycle as a write strobe is dropped.

Top module: `flash_status_model`

## Requirements
- R1: After reset, `ready` is 1, `rd_valid` is 0, and every byte reads FFh.
- R2: While idle, a read strobe at address A returns the byte stored at A in the next cycle, with `rd_valid` high for that one cycle.
- R3: Writing AAh at KEY_A, then 55h at KEY_B, then A0h at KEY_A, then data D at address A (the program sequence) drops `ready` for exactly PROG_CYC cycles, starting in the cycle after the fourth write. Afterwards the byte at A holds its old value AND D.
- R4: The status byte uses these bit positions: bit 7 is the poll bit, bit 6 the toggle bit, bit 5 the error bit and bit 3 the erase-window bit. All other bits read 0. During a program the poll bit is the inverse of bit 7 of D, and bits 5 and 3 read 0.
- R5: While status is returned, bit 6 inverts on every successive read of any address. Once the model is idle again, reads return array data and two reads of the same address are equal.
- R6: The erase sequence is AAh@KEY_A, 55h@KEY_B, 80h@KEY_A, AAh@KEY_A, 55h@KEY_B, then 30h at any address in sector S. The sector is the top SECT_W address bits. This sequence opens a window of WIN_CYC cycles with bit 3 = 0, followed by an erase of ERASE_CYC cycles with bit 3 = 1. Bit 7 reads 0 throughout. Afterwards sector S reads FFh and other sectors are unchanged.
- R7: A write of 30h during the window adds that address's sector to the erase set and closes the window in that same cycle, so bit 3 reads 1 from the next cycle.
- R8: Replacing the sixth write with 10h at KEY_A erases every unlocked sector. It has no window: `ready` is low for ERASE_CYC cycles.
- R9: A program sequence aimed at a locked sector is ignored: `ready` stays 1 and the byte is unchanged.
- R10: Locked sectors are skipped by an erase. If every selected sector is locked, bit 3 reads 1, bit 7 reads 0 and bit 6 toggles for LOCK_CYC cycles after the selection closes, and nothing is erased.
- R11: If a program asks for a 1 where a 0 is stored, the cycle still takes PROG_CYC cycles and stores old AND D. The model then stays in an error state: `ready` is 1, every read returns status with bit 5 = 1, and writes other than F0h are ignored.
- R12: A write of F0h in the error state clears the error, and reads return array data again.
- R13: Any write that does not match the next expected step of a sequence returns the decoder to its start state, and no command is issued.
- R14: While `ready` is 0, writes other than the R7 case are ignored, including complete command sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | ADDR_W | Byte address for read or write |
| host_wdata | input | 8 | Write data / command byte |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, dropped when host_wr is also high |
| sect_lock | input | 2**SECT_W | Per-sector lock, 1 = locked |
| rd_data | output | 8 | Array byte or status byte |
| rd_valid | output | 1 | High one cycle after an accepted read |
| ready | output | 1 | Low while an internal program or erase runs |

## Verification
The two functions that can meet in one cycle are the closing of the sector-erase window and the arrival of a further 30h write. The bench lands that write while the window counter is still running and checks that the erase starts on that very edge. This shows as a busy length of two window cycles plus the erase time, with both sectors cleared. A second collision is a complete command sequence written while a program is still running. It is judged by reading the target byte afterwards and by the unchanged busy length. A behavioural reference model is compared against `ready`, `rd_valid` and `rd_data` on every clock.

// File: rtl/flsm_pkg.sv
package flsm_pkg;
  typedef enum logic [2:0] {
    OP_IDLE, OP_PROG, OP_WIN, OP_ERASE, OP_LOCKW, OP_ERR
  } op_t;

  typedef enum logic [2:0] {
    SQ_START, SQ_K1, SQ_K2, SQ_PADDR, SQ_E1, SQ_E2, SQ_E3
  } seq_t;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_ALL   = 8'h10;
  localparam logic [7:0] CMD_RESET = 8'hF0;
endpackage

// File: rtl/flsm_cmd_seq.sv
module flsm_cmd_seq
  import flsm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int KEY_A  = 'h15,
  parameter int KEY_B  = 'h2A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              prog_req,
  output logic              sect_req,
  output logic              bulk_req
);
  localparam logic [ADDR_W-1:0] KA = ADDR_W'(KEY_A);
  localparam logic [ADDR_W-1:0] KB = ADDR_W'(KEY_B);

  seq_t st, st_nxt;
  logic at_a, at_b;

  assign at_a = (addr == KA);
  assign at_b = (addr == KB);

  always_comb begin
    st_nxt   = st;
    prog_req = 1'b0;
    sect_req = 1'b0;
    bulk_req = 1'b0;
    if (en && wr) begin
      st_nxt = SQ_START;
      unique case (st)
        SQ_START: if (at_a && wdata == CMD_KEY1) st_nxt = SQ_K1;
        SQ_K1:    if (at_b && wdata == CMD_KEY2) st_nxt = SQ_K2;
        SQ_K2: begin
          if (at_a && wdata == CMD_PROG)       st_nxt = SQ_PADDR;
          else if (at_a && wdata == CMD_ERASE) st_nxt = SQ_E1;
        end
        SQ_PADDR: prog_req = 1'b1;
        SQ_E1:    if (at_a && wdata == CMD_KEY1) st_nxt = SQ_E2;
        SQ_E2:    if (at_b && wdata == CMD_KEY2) st_nxt = SQ_E3;
        SQ_E3: begin
          if (wdata == CMD_SECT)               sect_req = 1'b1;
          else if (at_a && wdata == CMD_ALL)   bulk_req = 1'b1;
        end
        default: st_nxt = SQ_START;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= SQ_START;
    else     st <= st_nxt;
  end

  // R13
  one_req_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_req, sect_req, bulk_req}));
endmodule

// File: rtl/flsm_cell_array.sv
module flsm_cell_array #(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_byte,
  input  logic                     pg_we,
  input  logic [ADDR_W-1:0]        pg_addr,
  input  logic [7:0]               pg_data,
  input  logic                     er_we,
  input  logic [(1<<SECT_W)-1:0]   er_mask
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int SECTORS = 1 << SECT_W;
  localparam int SHIFT   = ADDR_W - SECT_W;

  logic [7:0] mem [DEPTH];

  assign rd_byte = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (er_we) begin
      for (int i = 0; i < DEPTH; i++)
        if (er_mask[i >> SHIFT]) mem[i] <= 8'hFF;
    end else if (pg_we) begin
      mem[pg_addr] <= mem[pg_addr] & pg_data;
    end
  end

  // R3
  bits_fall_chk: assert property (@(posedge clk) disable iff (rst)
    pg_we |=> ((mem[$past(pg_addr)] & ~$past(mem[pg_addr])) == 8'h00));

  // R6
  sect0_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (er_we && er_mask[0]) |=> (mem[0] == 8'hFF));

  logic unused_ok;
  assign unused_ok = (SECTORS > 0);
endmodule

// File: rtl/flsm_op_ctl.sv
module flsm_op_ctl
  import flsm_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 10,
  parameter int WIN_CYC   = 8,
  parameter int LOCK_CYC  = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  input  logic                    prog_req,
  input  logic                    sect_req,
  input  logic                    bulk_req,
  input  logic [(1<<SECT_W)-1:0]  lock,
  input  logic [7:0]              cell_byte,
  output logic                    idle,
  output logic                    busy,
  output logic                    stat_mode,
  output logic [7:0]              status,
  output logic                    pg_we,
  output logic [ADDR_W-1:0]       pg_addr,
  output logic [7:0]              pg_data,
  output logic                    er_we,
  output logic [(1<<SECT_W)-1:0]  er_mask
);
  localparam int SECTORS = 1 << SECT_W;
  localparam int M1   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int M2   = (WIN_CYC > LOCK_CYC) ? WIN_CYC : LOCK_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  function automatic logic [SECTORS-1:0] sec_bit(input logic [ADDR_W-1:0] a);
    return SECTORS'(1) << a[ADDR_W-1 -: SECT_W];
  endfunction

  op_t               st;
  logic [CW-1:0]     cnt;
  logic [SECTORS-1:0] sel, sel_in, eff;
  logic [ADDR_W-1:0] pa;
  logic [7:0]        pd;
  logic              tog, launch, conflict, last;

  assign last     = (cnt == '0);
  assign conflict = |(~cell_byte & pd);

  always_comb begin
    launch = 1'b0;
    sel_in = sel;
    if (st == OP_IDLE && bulk_req) begin
      launch = 1'b1;
      sel_in = '1;
    end else if (st == OP_WIN) begin
      if (wr && wdata == CMD_SECT) begin
        launch = 1'b1;
        sel_in = sel | sec_bit(addr);
      end else if (last) begin
        launch = 1'b1;
      end
    end
    eff = sel_in & ~lock;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= OP_IDLE; cnt <= '0; sel <= '0; er_mask <= '0;
      pa <= '0; pd <= 8'hFF; tog <= 1'b0;
    end else begin
      if (rd && st != OP_IDLE) tog <= ~tog;
      if (launch) begin
        sel <= sel_in;
        if (|eff) begin
          st <= OP_ERASE; cnt <= CW'(ERASE_CYC - 1); er_mask <= eff;
        end else begin
          st <= OP_LOCKW; cnt <= CW'(LOCK_CYC - 1);
        end
      end else begin
        unique case (st)
          OP_IDLE: begin
            if (prog_req && !lock[addr[ADDR_W-1 -: SECT_W]]) begin
              st <= OP_PROG; cnt <= CW'(PROG_CYC - 1); pa <= addr; pd <= wdata;
            end else if (sect_req) begin
              st <= OP_WIN; cnt <= CW'(WIN_CYC - 1); sel <= sec_bit(addr);
            end
          end
          OP_PROG: begin
            if (last) st <= conflict ? OP_ERR : OP_IDLE;
            else      cnt <= cnt - 1'b1;
          end
          OP_WIN:   cnt <= cnt - 1'b1;
          OP_ERASE, OP_LOCKW: begin
            if (last) st <= OP_IDLE;
            else      cnt <= cnt - 1'b1;
          end
          OP_ERR:  if (wr && wdata == CMD_RESET) st <= OP_IDLE;
          default: st <= OP_IDLE;
        endcase
      end
    end
  end

  assign idle      = (st == OP_IDLE);
  assign busy      = (st != OP_IDLE) && (st != OP_ERR);
  assign stat_mode = (st != OP_IDLE);
  assign pg_we     = (st == OP_PROG) && last;
  assign er_we     = (st == OP_ERASE) && last;
  assign pg_addr   = pa;
  assign pg_data   = pd;
  assign status    = {((st == OP_PROG) || (st == OP_ERR)) ? ~pd[7] : 1'b0,
                      tog,
                      (st == OP_ERR),
                      1'b0,
                      ((st == OP_ERASE) || (st == OP_LOCKW)),
                      3'b000};

  logic [CW-1:0] prog_run;
  always_ff @(posedge clk) begin
    if (rst || st != OP_PROG) prog_run <= '0;
    else                      prog_run <= prog_run + 1'b1;
  end

  // R3
  prog_len_chk: assert property (@(posedge clk) disable iff (rst)
    (st == OP_PROG && prog_run == CW'(PROG_CYC - 1)) |=> (st != OP_PROG));

  // R9
  lock_prog_chk: assert property (@(posedge clk) disable iff (rst)
    (st == OP_IDLE && prog_req && lock[addr[ADDR_W-1 -: SECT_W]]) |=> (st == OP_IDLE));
endmodule

// File: rtl/flash_status_model.sv
module flash_status_model #(
  parameter int ADDR_W    = 6,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 10,
  parameter int WIN_CYC   = 8,
  parameter int LOCK_CYC  = 7,
  parameter int KEY_A     = 'h15,
  parameter int KEY_B     = 'h2A
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [7:0]              host_wdata,
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [(1<<SECT_W)-1:0]  sect_lock,
  output logic [7:0]              rd_data,
  output logic                    rd_valid,
  output logic                    ready
);
  localparam int SECTORS = 1 << SECT_W;

  logic rd_ok, eng_idle, busy, stat_mode, prog_req, sect_req, bulk_req;
  logic pg_we, er_we;
  logic [7:0] status, cell_byte, pg_data;
  logic [ADDR_W-1:0] pg_addr, cell_addr;
  logic [SECTORS-1:0] er_mask;

  assign rd_ok = host_rd & ~host_wr;

  flsm_cmd_seq #(.ADDR_W(ADDR_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_seq (
    .clk(clk), .rst(rst), .en(eng_idle), .wr(host_wr), .addr(host_addr),
    .wdata(host_wdata), .prog_req(prog_req), .sect_req(sect_req), .bulk_req(bulk_req));

  flsm_op_ctl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC), .LOCK_CYC(LOCK_CYC)) u_ctl (
    .clk(clk), .rst(rst), .wr(host_wr), .rd(rd_ok), .addr(host_addr),
    .wdata(host_wdata), .prog_req(prog_req), .sect_req(sect_req),
    .bulk_req(bulk_req), .lock(sect_lock), .cell_byte(cell_byte),
    .idle(eng_idle), .busy(busy), .stat_mode(stat_mode), .status(status),
    .pg_we(pg_we), .pg_addr(pg_addr), .pg_data(pg_data), .er_we(er_we),
    .er_mask(er_mask));

  assign cell_addr = stat_mode ? pg_addr : host_addr;

  flsm_cell_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_arr (
    .clk(clk), .rst(rst), .rd_addr(cell_addr), .rd_byte(cell_byte),
    .pg_we(pg_we), .pg_addr(pg_addr), .pg_data(pg_data),
    .er_we(er_we), .er_mask(er_mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_ok;
      if (rd_ok) rd_data <= stat_mode ? status : cell_byte;
    end
  end

  assign ready = ~busy;

  // R5
  tog_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && stat_mode && $past(rd_ok && stat_mode && !rst))
      |=> (rd_data[6] != $past(rd_data[6])));

  // R11
  err_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && stat_mode && !busy) |=> rd_data[5]);
endmodule

// File: tb/flash_status_model_test.sv
`timescale 1ns/1ps
module flash_status_model_test;
  localparam int ADDR_W = 6, SECT_W = 2, PROG_CYC = 6, ERASE_CYC = 10;
  localparam int WIN_CYC = 8, LOCK_CYC = 7, KA = 'h15, KB = 'h2A;
  localparam int DEPTH = 1 << ADDR_W, SHIFT = ADDR_W - SECT_W;

  logic clk = 0, rst = 1;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_wr = 0, host_rd = 0;
  logic [3:0] sect_lock = '0;
  logic [7:0] rd_data;
  logic rd_valid, ready;

  flash_status_model uut (.clk(clk), .rst(rst), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_wr(host_wr), .host_rd(host_rd),
    .sect_lock(sect_lock), .rd_data(rd_data), .rd_valid(rd_valid), .ready(ready));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  string cur_req = "R1";

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: 0 idle,1 prog,2 window,3 erase,4 locked wait,5 error
  int ms = 0, mcnt = 0, dseq = 0, mpa = 0, mtog = 0;
  logic [7:0] mpd = 8'hFF, mmem [DEPTH];
  logic [3:0] msel = '0;
  logic [7:0] exp_rdata = 8'h00;
  logic exp_rvalid = 0;

  task automatic mlaunch(logic [3:0] s);
    logic [3:0] e;
    e = s & ~sect_lock;
    msel = s;
    if (e != 0) begin ms = 3; mcnt = ERASE_CYC; end
    else begin ms = 4; mcnt = LOCK_CYC; end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      ms = 0; mcnt = 0; dseq = 0; mtog = 0; mpd = 8'hFF;
      exp_rvalid = 0; exp_rdata = 8'h00;
      for (int i = 0; i < DEPTH; i++) mmem[i] = 8'hFF;
    end else begin
      int ms0, a, d;
      ms0 = ms; a = host_addr; d = host_wdata;
      exp_rvalid = host_rd && !host_wr;
      if (exp_rvalid) begin
        if (ms0 != 0) begin
          exp_rdata = {((ms0 == 1 || ms0 == 5) ? ~mpd[7] : 1'b0), mtog[0],
                       (ms0 == 5), 1'b0, (ms0 == 3 || ms0 == 4), 3'b000};
          mtog = mtog ^ 1;
        end else exp_rdata = mmem[a];
      end
      case (ms0)
        0: if (host_wr) begin
          case (dseq)
            0: dseq = (d == 'hAA && a == KA) ? 1 : 0;
            1: dseq = (d == 'h55 && a == KB) ? 2 : 0;
            2: dseq = (d == 'hA0 && a == KA) ? 3 : (d == 'h80 && a == KA) ? 4 : 0;
            3: begin
              if (!sect_lock[a >> SHIFT]) begin ms = 1; mcnt = PROG_CYC; mpa = a; mpd = d; end
              dseq = 0;
            end
            4: dseq = (d == 'hAA && a == KA) ? 5 : 0;
            5: dseq = (d == 'h55 && a == KB) ? 6 : 0;
            default: begin
              if (d == 'h30) begin ms = 2; mcnt = WIN_CYC; msel = 4'b1 << (a >> SHIFT); end
              else if (d == 'h10 && a == KA) mlaunch(4'hF);
              dseq = 0;
            end
          endcase
        end
        1: begin
          mcnt--;
          if (mcnt == 0) begin
            ms = ((~mmem[mpa] & mpd) != 0) ? 5 : 0;
            mmem[mpa] = mmem[mpa] & mpd;
          end
        end
        2: begin
          if (host_wr && d == 'h30) mlaunch(msel | (4'b1 << (a >> SHIFT)));
          else begin mcnt--; if (mcnt == 0) mlaunch(msel); end
        end
        3: begin
          mcnt--;
          if (mcnt == 0) begin
            for (int i = 0; i < DEPTH; i++)
              if ((msel & ~sect_lock) >> (i >> SHIFT) & 1) mmem[i] = 8'hFF;
            ms = 0;
          end
        end
        4: begin mcnt--; if (mcnt == 0) ms = 0; end
        default: if (host_wr && d == 'hF0) ms = 0;
      endcase
    end
  end

  // every-clock comparison with the model
  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_req, " ready"}, ready, (ms == 0 || ms == 5));
      chk({cur_req, " rd_valid"}, rd_valid, exp_rvalid);
      if (exp_rvalid) chk({cur_req, " rd_data"}, rd_data, exp_rdata);
    end
  end

  // busy-run length monitor
  int run_len = 0, last_len = 0;
  always @(negedge clk) begin
    if (!rst && !ready) run_len++;
    else if (run_len != 0) begin last_len = run_len; run_len = 0; end
  end

  task automatic bw(int a, int d);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic br(int a, output logic [7:0] v);
    host_addr = a; host_rd = 1;
    @(negedge clk); host_rd = 0; v = rd_data;
  endtask

  task automatic prog(int a, int d);
    bw(KA, 'hAA); bw(KB, 'h55); bw(KA, 'hA0); bw(a, d);
  endtask

  task automatic erase_pre();
    bw(KA, 'hAA); bw(KB, 'h55); bw(KA, 'h80); bw(KA, 'hAA); bw(KB, 'h55);
  endtask

  task automatic wait_idle();
    while (!ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk("R1 ready", ready, 1);
    chk("R1 rd_valid", rd_valid, 0);
    br(0, v); chk("R1 erased byte", v, 'hFF);
    cur_req = "R2";
    br(63, v); chk("R2 idle read", v, 'hFF);

    // R3 program, R14 writes during busy ignored
    cur_req = "R3";
    prog(5, 'h3C);
    cur_req = "R14";
    prog(9, 'h00);
    wait_idle();
    chk("R3 busy length", last_len, PROG_CYC);
    br(5, v); chk("R3 stored byte", v, 'h3C);
    br(9, v); chk("R14 write during busy ignored", v, 'hFF);

    // R4 / R5 status during program
    cur_req = "R4";
    prog(6, 'h5A);
    br(0, v); br(33, v2);
    chk("R4 poll bit inverted", v[7], 1);
    chk("R4 bits 5,3 and zeros", v & 8'h3F, 0);
    chk("R5 toggle inverts", v[6] ^ v2[6], 1);
    wait_idle();
    cur_req = "R5";
    br(6, v); br(6, v2);
    chk("R5 data after cycle", v, 'h5A);
    chk("R5 toggling stopped", v2, 'h5A);

    // R13 broken sequence
    cur_req = "R13";
    bw(KA, 'hAA); bw(KB, 'h55); bw(KA, 'h12); bw(7, 'h00);
    @(negedge clk);
    chk("R13 no busy after broken sequence", ready, 1);
    br(7, v); chk("R13 byte untouched", v, 'hFF);

    // R11 / R12 program conflict
    cur_req = "R11";
    prog(5, 'hC3);
    wait_idle();
    chk("R11 ready after failed cycle", ready, 1);
    br(0, v); chk("R11 error bit", v[5], 1);
    bw(KA, 'hAA);
    br(0, v); chk("R11 error held", v[5], 1);
    cur_req = "R12";
    bw(0, 'hF0);
    br(5, v); chk("R12 array back, old AND new", v, 'h00);

    // R6 sector erase
    cur_req = "R6";
    prog(20, 'h11); wait_idle();
    erase_pre(); bw(3, 'h30);
    br(0, v); chk("R6 window bit3 low, bit7 low", v & 8'h88, 'h00);
    repeat (WIN_CYC + 1) @(negedge clk);
    br(0, v); chk("R6 erase bit3 high, bit7 low", v & 8'h88, 'h08);
    wait_idle();
    chk("R6 busy length", last_len, WIN_CYC + ERASE_CYC);
    br(6, v); chk("R6 sector cleared", v, 'hFF);
    br(20, v); chk("R6 other sector kept", v, 'h11);

    // R7 extra sector closes window
    cur_req = "R7";
    prog(40, 'h22); wait_idle();
    prog(56, 'h33); wait_idle();
    erase_pre(); bw(40, 'h30);
    @(negedge clk);
    bw(56, 'h30);
    br(0, v); chk("R7 bit3 high after extra command", v[3], 1);
    wait_idle();
    chk("R7 busy length", last_len, 2 + ERASE_CYC);
    br(40, v); chk("R7 first sector", v, 'hFF);
    br(56, v); chk("R7 added sector", v, 'hFF);

    // R9 locked program
    cur_req = "R9";
    sect_lock = 4'b0010;
    prog(20, 'h01);
    chk("R9 ready stays high", ready, 1);
    br(20, v); chk("R9 byte unchanged", v, 'h11);

    // R10 erase of locked sector only
    cur_req = "R10";
    prog(5, 'h44); wait_idle();
    erase_pre(); bw(20, 'h30);
    repeat (WIN_CYC + 1) @(negedge clk);
    br(0, v); br(0, v2);
    chk("R10 bit3 high bit7 low", v & 8'h88, 'h08);
    chk("R10 toggle", v[6] ^ v2[6], 1);
    wait_idle();
    chk("R10 busy length", last_len, WIN_CYC + LOCK_CYC);
    br(20, v); chk("R10 nothing erased", v, 'h11);

    // R8 bulk erase, locked sector skipped
    cur_req = "R8";
    erase_pre(); bw(KA, 'h10);
    wait_idle();
    chk("R8 busy length", last_len, ERASE_CYC);
    br(5, v); chk("R8 unlocked erased", v, 'hFF);
    br(20, v); chk("R10 locked sector skipped", v, 'h11);
    cur_req = "R10";
    sect_lock = 4'hF;
    erase_pre(); bw(KA, 'h10);
    wait_idle();
    chk("R10 all locked wait", last_len, LOCK_CYC);
    sect_lock = 4'h0;
    cur_req = "R8";
    erase_pre(); bw(KA, 'h10);
    wait_idle();
    br(20, v); chk("R8 full erase", v, 'hFF);

    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule